// File: doc/BRIEF.md
# Synchronous Flip-Flop FIFO with Flow-Control Thresholds

This block is a single-clock first-in first-out buffer whose storage is an array of flip-flops. A producer presents a word on `datain` and raises `load`. A consumer raises `extract` to take the oldest stored word from `dataout`. The depth need not be a power of two, because both pointers wrap from the last entry back to zero.

Four status outputs support flow control. `empty` and `full` mark the two ends of the range. `almostfull` warns the producer while only a few free entries remain, so that words already in flight upstream can still be absorbed. `almostempty` warns the consumer while only a few filled entries remain. All four flags come from a single occupancy counter.

Two parameters choose build variants. `OUT_REG` puts a register stage on `dataout`. That register captures a word only on an accepted extract and is cleared by reset. `ASYNC_RST` chooses whether the active-low reset acts at once or at the next rising clock edge.

Top module: `sfifo_top`

## Requirements
- R1: While `rst_n` is low, the FIFO becomes empty: `empty`=1, `full`=0, `almostempty`=1, and `almostfull` = (DEPTH <= AF_DEPTH).
- R2: An accepted load appends `datain`, and words leave in the order they arrived. With `OUT_REG`=0, `dataout` shows the oldest stored word combinationally whenever the FIFO is not empty.
- R3: A load while `full`=1 and `extract`=0 is ignored: nothing is stored, occupancy is unchanged and `full` stays 1.
- R4: A load together with an extract while `full`=1 performs both: the oldest word leaves, `datain` is appended, and `full` stays 1.
- R5: An extract while `empty`=1 is ignored: the read position does not move and occupancy stays 0.
- R6: `empty` goes to 0 on the clock edge that accepts the first load, and returns to 1 on the edge that extracts the last stored word.
- R7: `full` is 1 exactly when the occupancy equals DEPTH. Occupancy never exceeds DEPTH.
- R8: `almostfull` is 1 exactly when (DEPTH − occupancy) <= AF_DEPTH.
- R9: `almostempty` is 1 exactly when occupancy <= AE_DEPTH.
- R10: With `OUT_REG`=1, `dataout` takes the extracted word on the edge of an accepted extract and keeps its value on every other edge, whatever loads occur.
- R11: With `OUT_REG`=1, reset clears `dataout` to 0.
- R12: With `ASYNC_RST`=1, a low `rst_n` clears the state at once, without a clock edge. With `ASYNC_RST`=0, the clear happens on the next rising edge of `clk`.
- R13: Reset does not alter the storage array. After reset, with `OUT_REG`=0, `dataout` shows the word last written to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Active-low reset; asynchronous or synchronous according to `ASYNC_RST` |
| load | input | 1 | Write request for `datain` |
| datain | input | WIDTH | Word to store |
| extract | input | 1 | Read request for the oldest word |
| dataout | output | WIDTH | Oldest word (combinational), or the last extracted word (registered) |
| empty | output | 1 | No entries are stored |
| full | output | 1 | All DEPTH entries are stored |
| almostfull | output | 1 | At most AF_DEPTH free entries remain |
| almostempty | output | 1 | At most AE_DEPTH filled entries remain |

## Verification
A load and an extract can be accepted on the same edge. The harder case is when the FIFO is full: the load must then be admitted because of the extract, and the occupancy must stay at DEPTH. The bench brings the FIFO to full and holds both requests high for several cycles. It also drives random load and extract streams whose bias shifts between filling and draining, so the coincidence also occurs at the empty end and at both thresholds. Each cycle is judged against a queue model in the bench: the returned word order, all four flags, and the held value of the registered output variant.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Width of a pointer that addresses `depth` entries (at least one bit).
  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Width of a counter that holds the values 0..depth.
  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/sfifo_rreg.sv
// Enabled register that resets to zero; ASYNC selects the reset flavour.
module sfifo_rreg #(
  parameter int unsigned W     = 1,
  parameter bit          ASYNC = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (ASYNC) begin : g_async
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
  end else begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
  end

endmodule

// File: rtl/sfifo_ctrl.sv
// Pointer and occupancy control with flag decode.
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH     = 6,
  parameter int unsigned AF_DEPTH  = 2,
  parameter int unsigned AE_DEPTH  = 1,
  parameter bit          ASYNC_RST = 1'b1,
  localparam int         AW        = ptr_bits(DEPTH),
  localparam int         CW        = cnt_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          extract,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] occ,
  output logic          empty,
  output logic          full,
  output logic          almostfull,
  output logic          almostempty
);

  localparam int SW = 2 * AW + CW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [SW-1:0] st_q, st_d;
  logic [AW-1:0] wptr_d, rptr_d;
  logic [CW-1:0] occ_d;
  int unsigned   occ_i;

  assign {wptr, rptr, occ} = st_q;

  // Acceptance: a load while full needs a same-cycle extract to make room.
  assign rd_en = extract && !empty;
  assign wr_en = load && (!full || extract);

  always_comb begin
    wptr_d = wptr;
    rptr_d = rptr;
    occ_d  = occ;
    if (wr_en) wptr_d = (wptr == LAST) ? '0 : wptr + 1'b1;
    if (rd_en) rptr_d = (rptr == LAST) ? '0 : rptr + 1'b1;
    case ({wr_en, rd_en})
      2'b10:   occ_d = occ + 1'b1;
      2'b01:   occ_d = occ - 1'b1;
      default: occ_d = occ;
    endcase
  end

  assign st_d = {wptr_d, rptr_d, occ_d};

  sfifo_rreg #(.W(SW), .ASYNC(ASYNC_RST)) u_state (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (1'b1),
    .d    (st_d),
    .q    (st_q)
  );

  assign occ_i       = 32'(occ);
  assign empty       = (occ == '0);
  assign full        = (occ_i == DEPTH);
  assign almostfull  = ((DEPTH - occ_i) <= AF_DEPTH);
  assign almostempty = (occ_i <= AE_DEPTH);

endmodule

// File: rtl/sfifo_store.sv
// Flip-flop storage: one write port, one asynchronous read port, no reset.
module sfifo_store #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 6,
  parameter int unsigned AW    = 3
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wptr,
  input  logic [WIDTH-1:0] din,
  input  logic [AW-1:0]    rptr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= din;
  end

  assign rdata = mem[rptr];

endmodule

// File: rtl/sfifo_top.sv
module sfifo_top
  import sfifo_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned DEPTH     = 6,
  parameter int unsigned AF_DEPTH  = 2,
  parameter int unsigned AE_DEPTH  = 1,
  parameter bit          OUT_REG   = 1'b0,
  parameter bit          ASYNC_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] datain,
  input  logic             extract,
  output logic [WIDTH-1:0] dataout,
  output logic             empty,
  output logic             full,
  output logic             almostfull,
  output logic             almostempty
);

  localparam int AW = ptr_bits(DEPTH);
  localparam int CW = cnt_bits(DEPTH);

  logic          wr_en, rd_en;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] occ;
  logic [WIDTH-1:0] rdata;

  sfifo_ctrl #(
    .DEPTH    (DEPTH),
    .AF_DEPTH (AF_DEPTH),
    .AE_DEPTH (AE_DEPTH),
    .ASYNC_RST(ASYNC_RST)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .extract    (extract),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wptr       (wptr),
    .rptr       (rptr),
    .occ        (occ),
    .empty      (empty),
    .full       (full),
    .almostfull (almostfull),
    .almostempty(almostempty)
  );

  sfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk  (clk),
    .wr_en(wr_en),
    .wptr (wptr),
    .din  (datain),
    .rptr (rptr),
    .rdata(rdata)
  );

  if (OUT_REG) begin : g_out_reg
    sfifo_rreg #(.W(WIDTH), .ASYNC(ASYNC_RST)) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (rd_en),
      .d    (rdata),
      .q    (dataout)
    );
  end else begin : g_out_comb
    assign dataout = rdata;
  end

endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk
  import sfifo_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned DEPTH   = 6,
  parameter bit          OUT_REG = 1'b0,
  localparam int         CW      = cnt_bits(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             extract,
  input logic [WIDTH-1:0] dataout,
  input logic             empty,
  input logic             full,
  input logic             almostfull,
  input logic             almostempty,
  input logic [CW-1:0]    occ
);

  // R3: a load into a full FIFO without an extract changes nothing
  a_r3_load_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (full && load && !extract) |=> (full && occ == $past(occ)));

  // R4: a load and an extract together keep a full FIFO full
  a_r4_full_both_keep_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && load && extract) |=> full);

  // R5: an extract from an empty FIFO is ignored
  a_r5_extract_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && extract && !load) |=> (empty && occ == '0));

  // R7: occupancy never goes past DEPTH
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R6/R7: the two end flags never coincide
  a_r6_ends_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R8: a full FIFO also reports almostfull
  a_r8_full_implies_af: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> almostfull);

  // R9: an empty FIFO also reports almostempty
  a_r9_empty_implies_ae: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> almostempty);

  if (OUT_REG) begin : g_reg_chk
    // R10: the registered output holds unless a valid extract occurs
    a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!extract || empty) |=> $stable(dataout));
  end

endmodule

bind sfifo_top sfifo_chk #(
  .WIDTH  (WIDTH),
  .DEPTH  (DEPTH),
  .OUT_REG(OUT_REG)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .extract    (extract),
  .dataout    (dataout),
  .empty      (empty),
  .full       (full),
  .almostfull (almostfull),
  .almostempty(almostempty),
  .occ        (occ)
);

// File: tb/sfifo_top_bench.sv
`timescale 1ns/1ps
module sfifo_top_bench;

  localparam int W  = 8;
  localparam int D  = 6;
  localparam int AF = 2;
  localparam int AE = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic extract = 1'b0;
  logic [W-1:0] datain = '0;

  logic [W-1:0] dout_c, dout_r;
  logic emp_c, ful_c, af_c, ae_c;
  logic emp_r, ful_r, af_r, ae_r;

  int total = 0;
  int bad = 0;

  logic [W-1:0] q[$];
  logic [W-1:0] sreg = '0;

  always #2.5 clk = ~clk;

  // Combinational output, asynchronous reset
  sfifo_top #(.WIDTH(W), .DEPTH(D), .AF_DEPTH(AF), .AE_DEPTH(AE),
              .OUT_REG(1'b0), .ASYNC_RST(1'b1)) u_sfifo_top (
    .clk(clk), .rst_n(rst_n), .load(load), .datain(datain), .extract(extract),
    .dataout(dout_c), .empty(emp_c), .full(ful_c),
    .almostfull(af_c), .almostempty(ae_c));

  // Registered output, synchronous reset
  sfifo_top #(.WIDTH(W), .DEPTH(D), .AF_DEPTH(AF), .AE_DEPTH(AE),
              .OUT_REG(1'b1), .ASYNC_RST(1'b0)) u_sfifo_top_reg (
    .clk(clk), .rst_n(rst_n), .load(load), .datain(datain), .extract(extract),
    .dataout(dout_r), .empty(emp_r), .full(ful_r),
    .almostfull(af_r), .almostempty(ae_r));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic bit exp_af(int n); return (D - n) <= AF; endfunction
  function automatic bit exp_ae(int n); return n <= AE; endfunction

  task automatic check_all();
    int n = q.size();
    check("R6 empty",       32'(emp_c), 32'(n == 0));
    check("R7 full",        32'(ful_c), 32'(n == D));
    check("R8 almostfull",  32'(af_c),  32'(exp_af(n)));
    check("R9 almostempty", 32'(ae_c),  32'(exp_ae(n)));
    check("R7 full reg",    32'(ful_r), 32'(n == D));
    check("R6 empty reg",   32'(emp_r), 32'(n == 0));
    if (n > 0) check("R2 order", 32'(dout_c), 32'(q[0]));
    check("R10 sampled out", 32'(dout_r), 32'(sreg));
  endtask

  task automatic step(bit ld, bit ex, logic [W-1:0] d);
    bit wr, rd;
    @(negedge clk);
    load = ld; extract = ex; datain = d;
    rd = ex && (q.size() > 0);
    wr = ld && ((q.size() < D) || ex);
    @(posedge clk);
    #1;
    if (rd) begin sreg = q[0]; void'(q.pop_front()); end
    if (wr) q.push_back(d);
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    load = 1'b0; extract = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 empty",       32'(emp_c), 32'd1);
    check("R1 full",        32'(ful_c), 32'd0);
    check("R1 almostempty", 32'(ae_c),  32'd1);
    check("R1 almostfull",  32'(af_c),  32'(D <= AF));
    check("R1 empty reg",   32'(emp_r), 32'd1);
    check("R11 out zero",   32'(dout_r), 32'd0);
    q.delete();
    sreg = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();

    // R2/R6/R7/R8: fill to the top
    for (int i = 0; i < D; i++) step(1'b1, 1'b0, W'(8'h10 + i));
    check("R7 full after DEPTH loads", 32'(ful_c), 32'd1);

    // R3: loads into a full FIFO are dropped
    step(1'b1, 1'b0, 8'hEE);
    check("R3 full stays", 32'(ful_c), 32'd1);
    step(1'b1, 1'b0, 8'hED);
    check("R3 head unchanged", 32'(dout_c), 32'h10);

    // R4: simultaneous load and extract while full, repeated
    for (int i = 0; i < D + 2; i++) begin
      step(1'b1, 1'b1, W'(8'h40 + i));
      check("R4 full stays", 32'(ful_c), 32'd1);
    end

    // R10: loads alone do not disturb the registered output
    step(1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b0, 8'h77);
    step(1'b1, 1'b0, 8'h78);

    // drain, R6 empty returns
    while (q.size() > 0) step(1'b0, 1'b1, 8'h00);
    check("R6 empty after last extract", 32'(emp_c), 32'd1);

    // R5: extracts while empty are ignored
    step(1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b1, 8'h00);
    check("R5 still empty", 32'(emp_c), 32'd1);
    step(1'b1, 1'b0, 8'hA5);
    check("R5 read position kept", 32'(dout_c), 32'hA5);
    check("R6 empty falls on first load", 32'(emp_c), 32'd0);
    // load with extract on an empty FIFO: only the load counts
    step(1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b1, 8'h5C);
    check("R5 load accepted on empty", 32'(emp_c), 32'd0);

    // R12: reset flavour, observed between clock edges
    step(1'b1, 1'b0, 8'h61);
    @(negedge clk);
    load = 1'b0; extract = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    check("R12 async clears at once", 32'(emp_c), 32'd1);
    check("R12 sync waits for edge",  32'(emp_r), 32'd0);
    @(posedge clk);
    #1;
    check("R12 sync clears on edge", 32'(emp_r), 32'd1);
    check("R11 out zero after reset", 32'(dout_r), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    q.delete();
    sreg = '0;

    // R13: storage survives reset
    step(1'b1, 1'b0, 8'h5A);
    step(1'b1, 1'b0, 8'h3C);
    do_reset();
    #1;
    check("R13 entry 0 kept", 32'(dout_c), 32'h5A);

    // Random traffic with shifting bias
    for (int blk = 0; blk < 8; blk++) begin
      int pl = (blk % 2 == 0) ? 75 : 35;
      int pe = (blk % 2 == 0) ? 40 : 70;
      for (int i = 0; i < 400; i++) begin
        bit ld = ($urandom % 100) < pl;
        bit ex = ($urandom % 100) < pe;
        step(ld, ex, W'($urandom));
      end
    end

    @(negedge clk);
    load = 1'b0; extract = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule